// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits behind a serial memory bus front-end and turns one write transaction into an update of a 256 x 8 storage array. The front-end reports three events: the start of a transaction with its word address, one strobe per received data byte, and the closing stop condition. Data bytes go into an eight-slot page buffer. The slot index comes from the low three bits of an address pointer, which wraps inside the page. The upper five bits name the page and stay fixed for the whole transaction.

Nothing reaches the array until the stop condition arrives. A stop with at least one buffered byte starts an internal write cycle. The cycle lasts a fixed number of clock cycles, set by `WRITE_CYCLES`, and `busy` is high for all of it. The front-end uses `busy` to withhold acknowledges, and every event that arrives during the cycle is dropped. When the cycle ends, all slots marked valid are written to the array together. A separate combinational read port gives the current array contents at any time.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy` is 0 and every array location reads 0x00.
- R2: `startValid` loads the 8-bit pointer from `startAddr`. Each accepted byte goes to array address {startAddr[7:3], slot}. The slot starts at startAddr[2:0] and increases by one per byte, modulo 8. No byte ever reaches a neighbouring page.
- R3: If more than eight bytes arrive before the stop, the slot index rolls over. A later byte replaces the earlier byte held in the same slot.
- R4: The array does not change before the stop. While `busy` is high, reads return the old contents.
- R5: A stop that finds at least one buffered byte sets `busy` on the next clock. `busy` then stays high for exactly `WRITE_CYCLES` cycles. The new data can be read in the first cycle after `busy` falls.
- R6: A commit updates only the slots written in this transaction. The other locations of the page, and all other pages, keep their values.
- R7: A stop with no buffered byte (address only) leaves `busy` low and the array unchanged.
- R8: While `busy` is high, start, byte and stop events are ignored. Bytes sent during the write cycle are never written. A stop sent during the cycle does not start a second cycle.
- R9: A new start discards the bytes buffered by an earlier transaction that had no stop. Those bytes are never committed.
- R10: If a byte strobe and a stop fall in the same cycle, the byte is buffered and included in the commit. This holds even when it is the only byte.
- R11: `rdData` shows the array entry at `rdAddr` combinationally, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | A transaction begins and its word address is on `startAddr` |
| startAddr | input | 8 | Starting word address |
| byteValid | input | 1 | One data byte is on `byteData` |
| byteData | input | 8 | Data byte to buffer |
| stopEvt | input | 1 | Stop condition that ends the transaction |
| busy | output | 1 | Internal write cycle in progress; acknowledges must be suppressed |
| rdAddr | input | 8 | Array read address |
| rdData | output | 8 | Array contents at `rdAddr` |

## Verification
Two functions can land in the same clock edge: storing a data byte and accepting the stop that triggers the commit. The bench raises `byteValid` and `stopEvt` together in one cycle. It does this once after an earlier byte, and once with no byte buffered before, so the byte alone decides whether a write cycle starts. It then judges two things. The write cycle must start, and the simultaneous byte must show at its wrapped address after `busy` falls. A second collision sits at the other end of the cycle. Events sent during the last busy cycle must not survive into the idle state.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Strobes sent from the control FSM to the datapath each cycle.
  typedef struct packed {
    logic loadPtr;    // latch start address, clear valid mask
    logic storeByte;  // write byte into current slot, advance low pointer
    logic commit;     // copy valid slots into the array
  } strobes_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl #(
  parameter int WRITE_CYCLES = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic               byteValid,
  input  logic               stopEvt,
  input  logic               maskAny,
  output logic               busy,
  output pwb_pkg::strobes_t  strobes
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cycLeft;
  logic             kickOff;

  // A stop starts a cycle only if data is buffered or arrives with it.
  assign kickOff = !busy && stopEvt && (maskAny || byteValid);

  always_comb begin
    strobes.loadPtr   = startValid && !busy;
    strobes.storeByte = byteValid && !busy && !startValid;
    strobes.commit    = busy && (cycLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cycLeft <= '0;
    end else if (kickOff) begin
      busy    <= 1'b1;
      cycLeft <= CNT_LOAD;
    end else if (busy) begin
      if (cycLeft == '0) busy <= 1'b0;
      else               cycLeft <= cycLeft - 1'b1;
    end
  end

  // R5: busy only ever rises right after a stop event
  a_r5_rise_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt));
  // R5: the commit strobe marks the final busy cycle
  a_r5_commit_ends: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !busy);
  // R7: stop with nothing buffered keeps the engine idle
  a_r7_empty_stop: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvt && !maskAny && !byteValid) |=> !busy);
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath #(
  parameter int ADDR_W = 8,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwb_pkg::strobes_t  strobes,
  input  logic               busy,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [DATA_W-1:0]  byteData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               maskAny
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << SLOT_W;
  localparam int HI_W  = ADDR_W - SLOT_W;

  logic [HI_W-1:0]   ptrHi;
  logic [SLOT_W-1:0] ptrLo;
  logic [SLOTS-1:0]  slotMask;
  logic [DATA_W-1:0] pageBuf [SLOTS];
  logic [DATA_W-1:0] mem     [DEPTH];

  assign maskAny = |slotMask;
  assign rdData  = mem[rdAddr];

  // Pointer, page buffer and valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrHi    <= '0;
      ptrLo    <= '0;
      slotMask <= '0;
      for (int i = 0; i < SLOTS; i++) pageBuf[i] <= '0;
    end else if (strobes.loadPtr) begin
      {ptrHi, ptrLo} <= startAddr;
      slotMask       <= '0;
    end else if (strobes.storeByte) begin
      pageBuf[ptrLo]  <= byteData;
      slotMask[ptrLo] <= 1'b1;
      ptrLo           <= ptrLo + 1'b1;   // wraps inside the page
    end else if (strobes.commit) begin
      slotMask <= '0;
    end
  end

  // Storage array: all valid slots land together on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < SLOTS; i++)
        if (slotMask[i]) mem[{ptrHi, SLOT_W'(i)}] <= pageBuf[i];
    end
  end

  // R2: page bits only change on a new start
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadPtr |=> $stable(ptrHi));
  // R3: low pointer advances by one per byte, modulo the page size
  a_r3_slot_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> ptrLo == SLOT_W'($past(ptrLo) + 1'b1));
  // R9: a new start empties the valid mask
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPtr |=> slotMask == '0);
  // R8: buffered state frozen while the write cycle runs
  a_r8_busy_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.commit) |=> ($stable(slotMask) && $stable(ptrLo)));
  // R6: nothing remains marked once committed
  a_r6_commit_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> slotMask == '0);
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ADDR_W       = 8,
  parameter int SLOT_W       = 3,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopEvt,
  output logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  pwb_pkg::strobes_t strobes;
  logic              maskAny;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .byteValid  (byteValid),
    .stopEvt    (stopEvt),
    .maskAny    (maskAny),
    .busy       (busy),
    .strobes    (strobes)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busy      (busy),
    .startAddr (startAddr),
    .byteData  (byteData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .maskAny   (maskAny)
  );
endmodule

// File: tb/sim_page_write_engine.sv
module sim_page_write_engine;
  localparam int WC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] startAddr = '0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       stopEvt = 1'b0;
  logic       busy;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;

  logic [7:0] model [256];
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  page_write_engine #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopEvt(stopEvt),
    .busy(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One cycle of events, applied on the falling edge
  task automatic pulse(input bit s, input logic [7:0] a, input bit b,
                       input logic [7:0] d, input bit p);
    @(negedge clk);
    startValid = s; startAddr = a; byteValid = b; byteData = d; stopEvt = p;
    @(negedge clk);
    startValid = 0; byteValid = 0; stopEvt = 0;
  endtask

  // Sweep the read port against the model (R11: combinational read)
  task automatic chkMem(input string req);
    int bad = -1;
    for (int a = 0; a < 256; a++) begin
      rdAddr = 8'(a); #1;
      if (bad < 0 && rdData !== model[a]) bad = a;
    end
    if (bad >= 0) begin
      rdAddr = 8'(bad); #1;
      chk(0, {req, " R11 mem"}, rdData, model[bad]);
    end else chk(1, req, 0, 0);
  endtask

  // Count busy cycles sampled at falling edges until idle
  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chkMem("R1 array cleared");
  endtask

  task automatic tSingle();
    int cyc;
    pulse(1, 8'h35, 0, 0, 0);
    pulse(0, 0, 1, 8'hA5, 0);
    rdAddr = 8'h35; #1;
    chk(rdData === 8'h00, "R4 before stop", rdData, 0);
    pulse(0, 0, 0, 0, 1);
    chk(busy === 1'b1, "R5 busy after stop", busy, 1);
    rdAddr = 8'h35; #1;
    chk(rdData === 8'h00, "R4 during busy", rdData, 0);
    waitIdle(cyc);
    chk(cyc == WC, "R5 busy length", cyc, WC);
    model[8'h35] = 8'hA5;
    chkMem("R5 R6 single byte");
  endtask

  task automatic tPageWrap();
    int cyc;
    pulse(1, 8'h5C, 0, 0, 0);
    for (int k = 0; k < 5; k++) pulse(0, 0, 1, 8'(8'h10 + k), 0);
    pulse(0, 0, 0, 0, 1);
    waitIdle(cyc);
    model[8'h5C] = 8'h10; model[8'h5D] = 8'h11; model[8'h5E] = 8'h12;
    model[8'h5F] = 8'h13; model[8'h58] = 8'h14;
    chkMem("R2 R6 wrap in page");
    rdAddr = 8'h60; #1;
    chk(rdData === 8'h00, "R2 no spill to next page", rdData, 0);
  endtask

  task automatic tRollover();
    int cyc;
    pulse(1, 8'h90, 0, 0, 0);
    for (int k = 0; k < 10; k++) pulse(0, 0, 1, 8'(8'hD0 + k), 0);
    pulse(0, 0, 0, 0, 1);
    waitIdle(cyc);
    for (int k = 0; k < 8; k++) model[8'h90 + k] = 8'(8'hD0 + k);
    model[8'h90] = 8'hD8; model[8'h91] = 8'hD9;
    chkMem("R3 overwrite");
  endtask

  task automatic tEmptyStop();
    bit sawBusy = 0;
    pulse(1, 8'h20, 0, 0, 0);
    pulse(0, 0, 0, 0, 1);
    for (int k = 0; k < 4; k++) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
    end
    chk(!sawBusy, "R7 no busy", sawBusy, 0);
    chkMem("R7 array unchanged");
  endtask

  task automatic tBusyIgnore();
    int cyc;
    bit sawBusy = 0;
    pulse(1, 8'hA0, 0, 0, 0);
    pulse(0, 0, 1, 8'h11, 0);
    pulse(0, 0, 0, 0, 1);
    pulse(1, 8'h00, 0, 0, 0);
    pulse(0, 0, 1, 8'hEE, 0);
    pulse(0, 0, 0, 0, 1);
    waitIdle(cyc);
    chk(cyc == WC - 6, "R8 cycle not restarted", cyc, WC - 6);
    model[8'hA0] = 8'h11;
    chkMem("R8 busy events dropped");
    // A stop now must find nothing buffered
    pulse(0, 0, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      if (busy) sawBusy = 1;
      @(negedge clk);
    end
    chk(!sawBusy, "R8 busy byte not kept", sawBusy, 0);
  endtask

  task automatic tAbandon();
    int cyc;
    pulse(1, 8'h40, 0, 0, 0);
    pulse(0, 0, 1, 8'h77, 0);
    pulse(1, 8'h48, 0, 0, 0);
    pulse(0, 0, 1, 8'h88, 0);
    pulse(0, 0, 0, 0, 1);
    waitIdle(cyc);
    model[8'h48] = 8'h88;
    chkMem("R9 old bytes discarded");
  endtask

  task automatic tSameCycle();
    int cyc;
    pulse(1, 8'hC7, 0, 0, 0);
    pulse(0, 0, 1, 8'h01, 0);
    pulse(0, 0, 1, 8'h02, 1);
    chk(busy === 1'b1, "R10 stop with byte", busy, 1);
    waitIdle(cyc);
    model[8'hC7] = 8'h01; model[8'hC0] = 8'h02;
    chkMem("R10 byte with stop included");
    pulse(1, 8'hD0, 0, 0, 0);
    pulse(0, 0, 1, 8'h5A, 1);
    chk(busy === 1'b1, "R10 lone byte starts cycle", busy, 1);
    waitIdle(cyc);
    model[8'hD0] = 8'h5A;
    chkMem("R10 lone byte committed");
  endtask

  initial begin
    #(200000 * 20);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSingle();
    tPageWrap();
    tRollover();
    tEmptyStop();
    tBusyIgnore();
    tAbandon();
    tSameCycle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule